// File: doc/BRIEF.md
# Fuse-programmed AND-OR logic array

This block is the configurable logic core of a ten-output programmable logic part. Eighteen array signals enter it: eight pin inputs (pin input 0 is the one that also serves as the clock pin) and ten feedbacks returned by the output cells. Each signal enters in true and inverted form, which gives 36 columns. Every one of the 96 product-term rows ANDs together the columns whose fuse is set. One row drives a common register clear, one drives a common synchronous set, and each output cell owns an enable row plus a set of logic rows whose OR forms its sum term. Output cells 4 and 5 get ten logic rows each; all the others get eight.

Configuration goes through a serial bit port. One address, one write bit and one registered read bit reach every fuse, the 20 cell mode bits and a 64-bit user signature, all through one linear address space. A security cell stops readback of the array and mode bits, but it leaves the signature readable. Only the full-erase strobe clears the security cell, and the same strobe wipes every stored bit.

Top module: `pt_array`

## Requirements
- R1: After reset every stored bit and the security cell are 0. Because no fuse is then set, every product term is true: `ar_o`, `sp_o`, all `oe_o` bits and all `sum_o` bits are 1, the mode outputs are 0 and `cfg_rdata` is 0.
- R2: The fuse for row r, column c sits at address r*36+c. Column 2k carries signal k true and column 2k+1 carries it inverted. Signals 0..7 are `arr_in[7:0]` and signals 8..17 are `fb_in[9:0]`. A product term is true exactly when every column whose fuse is 1 is true.
- R3: A product term with both columns of any one signal set is false for every input value.
- R4: Row 0 drives `ar_o` and row 95 drives `sp_o`. The rows from 1 to 94 are grouped by output cell in increasing cell order. Each group holds an enable row first and then its logic rows: 10 of them for cells 4 and 5, and 8 for all other cells.
- R5: `sum_o[m]` is the OR of cell m's logic rows. `oe_o[m]` is cell m's enable row, and that row has no effect on `sum_o[m]`.
- R6: The mode bit at address 3456+2m appears on `s0_o[m]`, and the bit at 3457+2m appears on `s1_o[m]`.
- R7: A write with `cfg_we` takes effect at the clock edge. `cfg_rdata` shows, one edge later, the bit that was stored at `cfg_addr` before that edge, so a read at the same address in the write cycle returns the old value.
- R8: Writing 1 to address 3540 sets the security cell, and reading 3540 returns its state. While the cell is set, reads of addresses below 3476 return 0, and the signature at 3476..3539 still reads its stored value.
- R9: Writing 0 to address 3540 does not clear the security cell. `cfg_erase` clears every stored bit and the security cell, and it wins over a write in the same cycle.
- R10: Writes to addresses above 3540 change nothing, and reads of those addresses return 0.
- R11: The security cell has no effect on `sum_o`, `oe_o`, `ar_o`, `sp_o`, `s0_o` or `s1_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 12 | Linear configuration bit address |
| cfg_we | input | 1 | Write strobe for one bit |
| cfg_wdata | input | 1 | Bit to write |
| cfg_erase | input | 1 | Full-erase strobe |
| cfg_rdata | output | 1 | Registered readback bit |
| arr_in | input | 8 | Pin input signals; bit 0 is the clock-shared pin |
| fb_in | input | 10 | Feedback signals from the output cells |
| sum_o | output | 10 | Sum term of each output cell |
| oe_o | output | 10 | Enable product term of each output cell |
| ar_o | output | 1 | Common register-clear product term |
| sp_o | output | 1 | Common synchronous-set product term |
| s0_o | output | 10 | First mode bit of each output cell |
| s1_o | output | 10 | Second mode bit of each output cell |

## Verification
The assertions assume that reset is applied before the first configuration access and that `cfg_addr`, `cfg_we` and `cfg_erase` are known at each clock edge. They also assume that a write to an address above 3540 comes without an erase in the same cycle. The bench therefore drives every configuration input at the falling edge. It issues erase and write together on purpose only in one directed case. Its random addresses span the full 12-bit range, so reads and writes outside the map are exercised along with those inside it.

// File: rtl/pt_array.sv
`timescale 1ns/1ps
module pt_array #(
  parameter int NIN       = 8,
  parameter int NMC       = 10,
  parameter int PT_NARROW = 8,
  parameter int PT_WIDE   = 10,
  parameter int WIDE_A    = 4,
  parameter int WIDE_B    = 5,
  parameter int SIGW      = 64,
  parameter int AW        = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  cfg_addr,
  input  logic           cfg_we,
  input  logic           cfg_wdata,
  input  logic           cfg_erase,
  output logic           cfg_rdata,
  input  logic [NIN-1:0] arr_in,
  input  logic [NMC-1:0] fb_in,
  output logic [NMC-1:0] sum_o,
  output logic [NMC-1:0] oe_o,
  output logic           ar_o,
  output logic           sp_o,
  output logic [NMC-1:0] s0_o,
  output logic [NMC-1:0] s1_o
);
  function automatic int pt_cnt(int m);
    return (m == WIDE_A || m == WIDE_B) ? PT_WIDE : PT_NARROW;
  endfunction

  function automatic int grp_base(int m);
    int b = 1;
    for (int j = 0; j < m; j++) b += 1 + pt_cnt(j);
    return b;
  endfunction

  localparam int NSIG      = NIN + NMC;
  localparam int NCOL      = 2 * NSIG;
  localparam int NROW      = grp_base(NMC) + 1;
  localparam int SP_ROW    = NROW - 1;
  localparam int MODE_BASE = NROW * NCOL;
  localparam int SIG_BASE  = MODE_BASE + 2 * NMC;
  localparam int SEC_ADDR  = SIG_BASE + SIGW;
  localparam int NFUSE     = SEC_ADDR;

  logic [NFUSE-1:0] fmem;
  logic             sec_q;
  logic             rdata_q;
  logic             rd_bit;
  logic [31:0]      addr_x;
  logic [NSIG-1:0]  sig;
  logic [NCOL-1:0]  lit;
  logic [NROW-1:0]  pt;

  assign addr_x    = 32'(cfg_addr);
  assign sig       = {fb_in, arr_in};
  assign cfg_rdata = rdata_q;

  for (genvar k = 0; k < NSIG; k++) begin : g_lit
    assign lit[2*k]   = sig[k];
    assign lit[2*k+1] = ~sig[k];
  end

  for (genvar r = 0; r < NROW; r++) begin : g_row
    assign pt[r] = &(lit | ~fmem[r*NCOL +: NCOL]);
  end

  for (genvar m = 0; m < NMC; m++) begin : g_cell
    localparam int B = grp_base(m);
    localparam int N = pt_cnt(m);
    assign oe_o[m]  = pt[B];
    assign sum_o[m] = |pt[B+1 +: N];
    assign s0_o[m]  = fmem[MODE_BASE + 2*m];
    assign s1_o[m]  = fmem[MODE_BASE + 2*m + 1];
  end

  assign ar_o = pt[0];
  assign sp_o = pt[SP_ROW];

  always_comb begin
    rd_bit = 1'b0;
    if (addr_x < 32'(SIG_BASE))      rd_bit = sec_q ? 1'b0 : fmem[cfg_addr];
    else if (addr_x < 32'(NFUSE))    rd_bit = fmem[cfg_addr];
    else if (addr_x == 32'(SEC_ADDR)) rd_bit = sec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmem    <= '0;
      sec_q   <= 1'b0;
      rdata_q <= 1'b0;
    end else begin
      if (cfg_erase) begin
        fmem  <= '0;
        sec_q <= 1'b0;
      end else if (cfg_we) begin
        if (addr_x < 32'(NFUSE)) fmem[cfg_addr] <= cfg_wdata;
        else if (addr_x == 32'(SEC_ADDR) && cfg_wdata) sec_q <= 1'b1;
      end
      rdata_q <= rd_bit;
    end
  end

  AST_ERASE_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_erase |=> (!sec_q && fmem == '0)); // R9
  AST_SEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q && !cfg_erase) |=> sec_q); // R9
  AST_BLOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q && addr_x < 32'(SIG_BASE)) |=> !cfg_rdata); // R8
  AST_OOR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_erase && addr_x > 32'(SEC_ADDR)) |=> ($stable(fmem) && $stable(sec_q))); // R10
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_x > 32'(SEC_ADDR)) |=> !cfg_rdata); // R10
  AST_FULL_ROW_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    (&fmem[NCOL-1:0]) |-> !ar_o); // R3
endmodule

// File: tb/test_pt_array.sv
`timescale 1ns/1ps
module test_pt_array;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic       cfg_we = 1'b0, cfg_wdata = 1'b0, cfg_erase = 1'b0;
  logic       cfg_rdata;
  logic [7:0] arr_in = '0;
  logic [9:0] fb_in = '0;
  logic [9:0] sum_o, oe_o, s0_o, s1_o;
  logic       ar_o, sp_o;

  int n_chk = 0, n_fail = 0;
  bit mdl [3540];
  bit msec = 1'b0;

  always #2 clk = ~clk;

  pt_array i_pt_array (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_erase(cfg_erase), .cfg_rdata(cfg_rdata),
    .arr_in(arr_in), .fb_in(fb_in), .sum_o(sum_o), .oe_o(oe_o),
    .ar_o(ar_o), .sp_o(sp_o), .s0_o(s0_o), .s1_o(s1_o));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit lit_exp(int c);
    int k = c / 2;
    bit s = (k < 8) ? arr_in[k] : fb_in[k-8];
    return (c % 2) ? !s : s;
  endfunction

  function automatic bit pt_exp(int r);
    for (int c = 0; c < 36; c++)
      if (mdl[r*36+c] && !lit_exp(c)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int nlog(int m);
    return (m == 4 || m == 5) ? 10 : 8;
  endfunction

  function automatic int gbase(int m);
    int b = 1;
    for (int j = 0; j < m; j++) b += 1 + nlog(j);
    return b;
  endfunction

  function automatic bit rd_exp(int a);
    if (a < 3476) return msec ? 1'b0 : mdl[a];
    if (a < 3540) return mdl[a];
    if (a == 3540) return msec;
    return 1'b0;
  endfunction

  task automatic check_outputs(string tag);
    logic [9:0] es, eo, e0, e1;
    for (int m = 0; m < 10; m++) begin
      int b = gbase(m);
      eo[m] = pt_exp(b);
      es[m] = 1'b0;
      for (int i = 1; i <= nlog(m); i++) es[m] |= pt_exp(b + i);
      e0[m] = mdl[3456 + 2*m];
      e1[m] = mdl[3457 + 2*m];
    end
    chk({"R5 sum ", tag}, int'(sum_o), int'(es));
    chk({"R5 oe ", tag}, int'(oe_o), int'(eo));
    chk({"R4 ar ", tag}, int'(ar_o), int'(pt_exp(0)));
    chk({"R4 sp ", tag}, int'(sp_o), int'(pt_exp(95)));
    chk({"R6 s0 ", tag}, int'(s0_o), int'(e0));
    chk({"R6 s1 ", tag}, int'(s1_o), int'(e1));
  endtask

  task automatic do_wr(int a, bit v);
    @(negedge clk);
    cfg_addr = a[11:0]; cfg_wdata = v; cfg_we = 1'b1;
    @(posedge clk);
    #1 cfg_we = 1'b0;
    if (a < 3540) mdl[a] = v;
    else if (a == 3540 && v) msec = 1'b1;
  endtask

  task automatic do_erase();
    @(negedge clk);
    cfg_erase = 1'b1;
    @(posedge clk);
    #1 cfg_erase = 1'b0;
    foreach (mdl[i]) mdl[i] = 1'b0;
    msec = 1'b0;
  endtask

  task automatic do_rd(int a, string req);
    @(negedge clk);
    cfg_addr = a[11:0];
    @(posedge clk);
    @(negedge clk);
    chk(req, int'(cfg_rdata), int'(rd_exp(a)));
  endtask

  task automatic kill_row(int r);
    do_wr(r*36, 1'b1);
    do_wr(r*36 + 1, 1'b1);
  endtask

  task automatic prog_random(int dens);
    do_erase();
    for (int a = 0; a < 3540; a++)
      if ((a < 3456) ? ($urandom % dens == 0) : ($urandom % 2 == 1)) do_wr(a, 1'b1);
  endtask

  task automatic rand_inputs(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      arr_in = 8'($urandom);
      fb_in  = 10'($urandom);
      #1 check_outputs(tag);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #9 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 ar", int'(ar_o), 1);
    chk("R1 sp", int'(sp_o), 1);
    chk("R1 oe", int'(oe_o), 10'h3ff);
    chk("R1 sum", int'(sum_o), 10'h3ff);
    chk("R1 modes", int'({s0_o, s1_o}), 0);
    chk("R1 rdata", int'(cfg_rdata), 0);

    // R2 single literal on the clear row
    do_wr(0, 1'b1);
    @(negedge clk); arr_in = 8'h01; #1 chk("R2 ar true lit", int'(ar_o), 1);
    @(negedge clk); arr_in = 8'h00; #1 chk("R2 ar true lit low", int'(ar_o), 0);
    do_wr(3, 1'b1);
    @(negedge clk); arr_in = 8'h00; #1 chk("R2 ar compl lit", int'(ar_o), 0);
    // R3 both polarities of one signal
    do_wr(1, 1'b1);
    @(negedge clk); arr_in = 8'h01; #1 chk("R3 ar contradiction hi", int'(ar_o), 0);
    @(negedge clk); arr_in = 8'h00; #1 chk("R3 ar contradiction lo", int'(ar_o), 0);

    // R4 set row uses feedback 0 true (column 16)
    do_erase();
    do_wr(95*36 + 16, 1'b1);
    @(negedge clk); fb_in = 10'h001; #1 chk("R4 sp fb0 hi", int'(sp_o), 1);
    @(negedge clk); fb_in = 10'h000; #1 chk("R4 sp fb0 lo", int'(sp_o), 0);

    // R4 R5 wide cell 4: only its tenth logic row stays live
    for (int r = gbase(4) + 1; r < gbase(4) + 10; r++) kill_row(r);
    do_wr((gbase(4) + 10)*36 + 5, 1'b1);
    kill_row(gbase(4));
    @(negedge clk); arr_in = 8'h00; #1
    chk("R4 cell4 tenth row", int'(sum_o[4]), 1);
    chk("R5 cell4 oe off", int'(oe_o[4]), 0);
    @(negedge clk); arr_in = 8'h04; #1 chk("R4 cell4 tenth row lo", int'(sum_o[4]), 0);
    check_outputs("directed");

    // R6 mode bit placement
    do_wr(3456 + 2*3 + 1, 1'b1);
    #1 chk("R6 s1 cell3", int'(s1_o), 10'h008);
    chk("R6 s0 none", int'(s0_o), 0);

    // R7 same-cycle write and read returns old value
    do_wr(200, 1'b1);
    @(negedge clk); chk("R7 old value", int'(cfg_rdata), 0);
    @(posedge clk); @(negedge clk); chk("R7 new value", int'(cfg_rdata), 1);

    // Random programs with random inputs and readback
    for (int p = 0; p < 3; p++) begin
      prog_random(9 + 3*p);
      rand_inputs(120, "random");
      for (int i = 0; i < 40; i++) do_rd(int'($urandom % 4096), "R7 R10 readback");
    end

    // R8 R11 security
    do_wr(100, 1'b1);
    do_wr(3500, 1'b1);
    do_wr(3540, 1'b0);
    do_rd(3540, "R9 zero write no set");
    do_wr(3540, 1'b1);
    do_rd(3540, "R8 sec set");
    do_rd(100, "R8 array blocked");
    do_rd(3460, "R8 mode blocked");
    do_rd(3500, "R8 signature readable");
    for (int i = 0; i < 30; i++) do_rd(int'($urandom % 3541), "R8 secured readback");
    rand_inputs(40, "R11 secured");
    do_wr(3540, 1'b0);
    do_rd(3540, "R9 zero write keeps sec");

    // R9 erase wins over write
    @(negedge clk);
    cfg_addr = 12'd100; cfg_wdata = 1'b1; cfg_we = 1'b1; cfg_erase = 1'b1;
    @(posedge clk);
    #1 cfg_we = 1'b0; cfg_erase = 1'b0;
    foreach (mdl[i]) mdl[i] = 1'b0;
    msec = 1'b0;
    do_rd(100, "R9 erase beats write");
    do_rd(3540, "R9 erase clears sec");
    do_rd(3500, "R9 erase clears signature");

    // R10 out-of-range writes
    prog_random(10);
    do_wr(3600, 1'b1);
    do_wr(4095, 1'b1);
    do_rd(3600, "R10 oor read");
    do_rd(3540, "R10 sec untouched");
    rand_inputs(20, "R10 after oor");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule